// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a 24-bit down-counter that a processor programs through four word registers: a control and status word, a reload value, a live count and a fixed calibration word. The counter advances only on single-cycle tick strobes. A control bit picks which of two strobe inputs it follows: a fast strobe derived from the core clock or a slower reference strobe. Each time the count runs out, the block latches a sticky expiry flag. When the interrupt-enable bit is set, it also emits a one-cycle interrupt-pending pulse toward an interrupt controller.

A small state machine sequences the counter through three states. ST_IDLE holds the count at zero while the timer is off. ST_LOAD waits for the next selected tick to copy in the reload value. ST_COUNT decrements on each tick. The transitions are named as follows. *arm* (ST_IDLE to ST_LOAD) happens when enable is set and no tick arrives. *direct load* (ST_IDLE to ST_COUNT) happens when enable is set and a tick arrives in the same cycle. *load* (ST_LOAD to ST_COUNT) happens on a tick. *wrap* (ST_COUNT to ST_LOAD) happens on expiry with a non-zero reload. *self-stop* (ST_COUNT to ST_IDLE) happens on expiry with a zero reload. *restart* (any enabled state to ST_LOAD) happens on a write to the live count. *disable* (any state to ST_IDLE) happens when enable is cleared.

Software uses the flag for polling and the pulse for interrupts. A one-shot delay is made by loading a zero reload while the counter is running.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word, reload and live count all read 0, and the interrupt output is low.
- R2: Register offsets are control 0x10, reload 0x14, live count 0x18 and calibration 0x1C. The reload register keeps only bits 23:0, and bits 31:24 read 0.
- R3: The calibration register always reads 10000 (decimal).
- R4: With reload value N ≥ 1, the first expiry falls on the (N+1)th selected tick after enable is set, and each later expiry comes N+1 ticks after the one before. The live count reads N after the first tick and then falls by one per tick.
- R5: Every expiry sets the flag at control bit 16. The interrupt output pulses high for exactly one cycle per expiry, and only when control bit 1 (interrupt enable) is 1.
- R6: A read of the control word returns the flag as it stood, and then clears it.
- R7: If the reload value is 0 when the count expires, control bit 0 (enable) clears itself and counting stops.
- R8: The live count reads 0 whenever enable (control bit 0) is 0, and ticks have no effect while disabled.
- R9: With control bit 2 at 1 the counter follows the core tick input. With bit 2 at 0 it follows the reference tick input, and the other input is ignored.
- R10: Any write to the live-count register zeroes the count and clears the flag, and the next selected tick reloads the count from the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_tick | input | 1 | Fast tick strobe, one cycle per tick |
| ref_tick | input | 1 | Slow reference tick strobe, one cycle per tick |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq_o | output | 1 | One-cycle interrupt-pending pulse on expiry |

## Verification
The hardest case to reach from the ports is the self-stop transition. It needs the reload register to read zero at the exact tick where the count runs out, yet loading zero from the start must still give a counter that started. The bench arms the counter with a non-zero reload, spends one tick on the load, and only then rewrites the reload to zero. The following ticks therefore drain the count already loaded and land on expiry with a zero reload. The bench also steps ticks one at a time between register accesses, so that a flag read never falls on the same cycle as an expiry.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int DATA_W = 32;

    localparam logic [7:0] OFF_CTRL  = 8'h10;
    localparam logic [7:0] OFF_RELD  = 8'h14;
    localparam logic [7:0] OFF_LIVE  = 8'h18;
    localparam logic [7:0] OFF_CALIB = 8'h1C;

    localparam int BIT_EN    = 0;
    localparam int BIT_INTEN = 1;
    localparam int BIT_CORE  = 2;
    localparam int BIT_FLAG  = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/tick_src_sel.sv
module tick_src_sel (
    input  logic sel_core,
    input  logic core_tick,
    input  logic ref_tick,
    output logic tick
);
    always_comb begin
        tick = sel_core ? core_tick : ref_tick;
    end
endmodule

// File: rtl/tick_core_fsm.sv
module tick_core_fsm
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             stop
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             runs_out;

    always_comb begin
        runs_out = (state_q == ST_COUNT) && en && !restart && tick && (count_q <= CNT_ONE);
    end

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (!en) begin
            state_d = ST_IDLE;
            count_d = '0;
        end else if (restart) begin
            state_d = ST_LOAD;
            count_d = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tick) begin
                        state_d = ST_COUNT;
                        count_d = reload;
                    end else begin
                        state_d = ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (tick) begin
                        state_d = ST_COUNT;
                        count_d = reload;
                    end
                end
                ST_COUNT: begin
                    if (tick) begin
                        if (count_q <= CNT_ONE) begin
                            count_d = '0;
                            state_d = (reload == '0) ? ST_IDLE : ST_LOAD;
                        end else begin
                            count_d = count_q - CNT_ONE;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    count_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    always_comb begin
        count  = count_q;
        expire = runs_out;
        stop   = runs_out && (reload == '0);
    end

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (count_q == '0));

    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && en && !restart && !tick) |=> $stable(count_q));

    p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && en && !restart && tick) |=> (count_q == $past(reload)));

    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state_q == ST_IDLE));
endmodule

// File: rtl/tick_csr.sv
module tick_csr
    import tick_timer_pkg::*;
#(
    parameter int          CNT_W  = 24,
    parameter int          ADDR_W = 8,
    parameter logic [31:0] CALIB  = 32'd10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    input  logic              stop,
    output logic              en,
    output logic              sel_core,
    output logic              restart,
    output logic [CNT_W-1:0]  reload,
    output logic              irq
);
    localparam int PAD_W = DATA_W - CNT_W;

    logic             en_q, inten_q, core_q, flag_q, irq_q;
    logic [CNT_W-1:0] reload_q;
    logic             hit_ctrl, hit_reld, hit_live, hit_calib;
    logic             wr_ctrl, wr_reld, rd_ctrl;

    always_comb begin
        hit_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
        hit_reld  = (bus_addr == ADDR_W'(OFF_RELD));
        hit_live  = (bus_addr == ADDR_W'(OFF_LIVE));
        hit_calib = (bus_addr == ADDR_W'(OFF_CALIB));
        wr_ctrl   = bus_en &&  bus_we && hit_ctrl;
        wr_reld   = bus_en &&  bus_we && hit_reld;
        rd_ctrl   = bus_en && !bus_we && hit_ctrl;
        restart   = bus_en &&  bus_we && hit_live;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            inten_q <= 1'b0;
            core_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                inten_q <= bus_wdata[BIT_INTEN];
                core_q  <= bus_wdata[BIT_CORE];
            end
            if (stop)         en_q <= 1'b0;
            else if (wr_ctrl) en_q <= bus_wdata[BIT_EN];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (expire)             flag_q <= 1'b1;
        else if (rd_ctrl || restart) flag_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       reload_q <= '0;
        else if (wr_reld) reload_q <= bus_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= expire && inten_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[BIT_EN]    = en_q;
            bus_rdata[BIT_INTEN] = inten_q;
            bus_rdata[BIT_CORE]  = core_q;
            bus_rdata[BIT_FLAG]  = flag_q;
        end else if (hit_reld) begin
            bus_rdata = {{PAD_W{1'b0}}, reload_q};
        end else if (hit_live) begin
            bus_rdata = en_q ? {{PAD_W{1'b0}}, count} : '0;
        end else if (hit_calib) begin
            bus_rdata = CALIB;
        end
    end

    always_comb begin
        en       = en_q;
        sel_core = core_q;
        reload   = reload_q;
        irq      = irq_q;
    end

    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(inten_q));

    p_irq_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> flag_q);

    p_stop_clears_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !en_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int          CNT_W  = 24,
    parameter int          ADDR_W = 8,
    parameter logic [31:0] CALIB  = 32'd10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_tick,
    input  logic              ref_tick,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    logic             en, sel_core, restart, tick, expire, stop;
    logic [CNT_W-1:0] reload, count;

    tick_src_sel u_src (
        .sel_core  (sel_core),
        .core_tick (core_tick),
        .ref_tick  (ref_tick),
        .tick      (tick)
    );

    tick_core_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .tick    (tick),
        .restart (restart),
        .reload  (reload),
        .count   (count),
        .expire  (expire),
        .stop    (stop)
    );

    tick_csr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CALIB(CALIB)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count),
        .expire    (expire),
        .stop      (stop),
        .en        (en),
        .sel_core  (sel_core),
        .restart   (restart),
        .reload    (reload),
        .irq       (irq_o)
    );

    p_live_zero_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == ADDR_W'(OFF_LIVE) && !en) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_tick = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    localparam logic [7:0] A_CTRL = 8'h10, A_RELD = 8'h14, A_LIVE = 8'h18, A_CAL = 8'h1C;

    always #4 clk = ~clk;

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .core_tick(core_tick), .ref_tick(ref_tick),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic pulse(input bit core, output bit irq_seen);
        if (core) core_tick = 1'b1; else ref_tick = 1'b1;
        @(negedge clk);
        core_tick = 1'b0; ref_tick = 1'b0;
        irq_seen = irq_o;
    endtask

    task automatic pulses_until_irq(input bit core, input int max, output int n);
        bit s;
        n = 0;
        for (int i = 1; i <= max; i++) begin
            pulse(core, s);
            if (s) begin n = i; break; end
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        rd(A_CTRL, v);  check("R1 ctrl", v, 32'h0);
        rd(A_RELD, v);  check("R1 reload", v, 32'h0);
        rd(A_LIVE, v);  check("R1 live", v, 32'h0);
        rd(A_CAL, v);   check("R3 calib", v, 32'd10000);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(A_RELD, 32'hFFFF_FFFF);
        rd(A_RELD, v);  check("R2 reload width", v, 32'h00FF_FFFF);
        wr(A_CAL, 32'h0);
        rd(A_CAL, v);   check("R3 calib fixed", v, 32'd10000);
    endtask

    task automatic t_period;
        logic [31:0] v; bit s; int n;
        wr(A_RELD, 32'd4);
        wr(A_CTRL, 32'h7);
        for (int i = 0; i < 3; i++) begin
            pulse(1'b1, s); check("R5 no early irq", {31'b0, s}, 32'h0);
        end
        rd(A_LIVE, v);  check("R4 live after 3 ticks", v, 32'd2);
        pulse(1'b1, s); check("R4 no irq tick 4", {31'b0, s}, 32'h0);
        pulse(1'b1, s); check("R4 irq on tick 5", {31'b0, s}, 32'h1);
        @(negedge clk);
        check("R5 irq one cycle", {31'b0, irq_o}, 32'h0);
        rd(A_CTRL, v);  check("R6 flag seen", v, 32'h0001_0007);
        rd(A_CTRL, v);  check("R6 flag cleared", v, 32'h0000_0007);
        pulses_until_irq(1'b1, 20, n);
        check("R4 second period", n, 32'd5);
    endtask

    task automatic t_noint;
        logic [31:0] v; int n;
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v);
        wr(A_RELD, 32'd2);
        wr(A_CTRL, 32'h5);
        pulses_until_irq(1'b1, 3, n);
        check("R5 no irq when disabled", n, 32'd0);
        rd(A_CTRL, v);  check("R5 flag without irq", v, 32'h0001_0005);
    endtask

    task automatic t_src;
        logic [31:0] v; int n;
        wr(A_CTRL, 32'h0);
        wr(A_RELD, 32'd2);
        wr(A_CTRL, 32'h3);
        pulses_until_irq(1'b1, 6, n);
        check("R9 core tick ignored", n, 32'd0);
        rd(A_LIVE, v);  check("R9 live untouched", v, 32'd0);
        pulses_until_irq(1'b0, 10, n);
        check("R9 ref tick period", n, 32'd3);
    endtask

    task automatic t_oneshot;
        logic [31:0] v; bit s; int n;
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v);
        wr(A_RELD, 32'd3);
        wr(A_CTRL, 32'h7);
        pulse(1'b1, s);
        wr(A_RELD, 32'd0);
        pulses_until_irq(1'b1, 5, n);
        check("R7 last expiry", n, 32'd3);
        rd(A_CTRL, v);  check("R7 enable self-cleared", v, 32'h0001_0006);
        pulses_until_irq(1'b1, 4, n);
        check("R7 stopped", n, 32'd0);
        rd(A_LIVE, v);  check("R8 live zero when off", v, 32'd0);
    endtask

    task automatic t_livewr;
        logic [31:0] v; bit s; int n;
        wr(A_CTRL, 32'h0);
        wr(A_RELD, 32'd5);
        wr(A_CTRL, 32'h5);
        for (int i = 0; i < 6; i++) pulse(1'b1, s);
        wr(A_LIVE, 32'h123);
        rd(A_CTRL, v);  check("R10 flag cleared by live write", v, 32'h0000_0005);
        rd(A_LIVE, v);  check("R10 count zeroed", v, 32'd0);
        pulse(1'b1, s);
        rd(A_LIVE, v);  check("R10 reload on next tick", v, 32'd5);
        pulse(1'b1, s); pulse(1'b1, s);
        rd(A_LIVE, v);  check("R4 decrement", v, 32'd3);
        wr(A_CTRL, 32'h4);
        rd(A_LIVE, v);  check("R8 live zero after disable", v, 32'd0);
        pulses_until_irq(1'b1, 8, n);
        rd(A_CTRL, v);  check("R8 no expiry while off", v, 32'h0000_0004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_period;
        t_noint;
        t_src;
        t_oneshot;
        t_livewr;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog R4 actual=timeout expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule